// File: doc/BRIEF.md
# Command-Response Buffer Pointer Tracker

This block follows where an external bus master is reading from and writing to a slave-side byte buffer while a command/response exchange runs over I2C or SPI. The protocol engines and the buffer memory stay outside. The block sees only their one-cycle event strobes and the SPI slave-select level. From these it keeps a read pointer and a write pointer. Each pointer is loaded from a configured base address when an addressed transaction opens, and moves forward by one per byte access of its own kind. Software finds the byte count of a finished exchange by subtracting the base from the pointer.

All results appear in one 32-bit status word. Besides the two pointers, the word carries a bus-busy flag and an update-in-progress flag. The update-in-progress flag marks the cycles in which a pointer value is changing and should not be trusted. Every input is a plain control strobe or level. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure: each strobe counts in the cycle it is high.

Top module: `cr_ptr_tracker`

## Requirements
- R1: The status word carries the read pointer in bits 8:0, the write pointer in bits 24:16, bus-busy in bit 30 and update-in-progress in bit 31. Bits 15:9 and 29:25 always read 0.
- R2: While reset (active-low `rst_n`) is applied, and in the first cycle after it, the whole status word is 0.
- R3: When a transaction opens, both pointers take the values of `base_rd_addr` and `base_wr_addr` as sampled in that cycle, visible one cycle later. In I2C mode (`mode_spi`=0) a transaction opens on `addr_match_ok`. In SPI mode (`mode_spi`=1) it opens in the cycle `spi_sel` goes from 0 to 1.
- R4: Inside an open transaction, each `rd_strobe` adds 1 to the read pointer and each `wr_strobe` adds 1 to the write pointer, visible one cycle later. The bytes moved equal the pointer minus its base.
- R5: A pointer at 511 stays at 511 on a further access and never wraps.
- R6: Access strobes leave both pointers unchanged outside an open transaction. In I2C mode that means before `addr_match_ok`, after STOP, after RESTART until the next match, and after a failed match. In SPI mode it means while `spi_sel` is 0 and in the cycle `spi_sel` rises.
- R7: In I2C mode, bus-busy becomes 1 in the cycle after `i2c_start` or `i2c_restart`. It becomes 0 in the cycle after `i2c_stop` or `addr_match_fail`.
- R8: In SPI mode, bus-busy equals `spi_sel` delayed by one cycle.
- R9: An access that moves a pointer holds update-in-progress at 1 for the next 1 cycle in I2C mode, or the next 2 cycles in SPI mode. An access to a pointer already at 511 does not raise it, and it is 0 whenever bus-busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_spi | input | 1 | 0 = I2C event rules, 1 = SPI event rules |
| base_rd_addr | input | 9 | Configured read base address |
| base_wr_addr | input | 9 | Configured write base address |
| rd_strobe | input | 1 | One byte read from the buffer |
| wr_strobe | input | 1 | One byte written to the buffer |
| i2c_start | input | 1 | I2C START seen |
| i2c_restart | input | 1 | I2C repeated START seen |
| i2c_stop | input | 1 | I2C STOP seen |
| addr_match_ok | input | 1 | I2C address matched this slave |
| addr_match_fail | input | 1 | I2C address did not match |
| spi_sel | input | 1 | SPI slave select active (level) |
| status_word | output | 32 | Packed pointers and flags |

## Verification
Every result is registered, so pointer loads, increments and bus-busy changes are due exactly one cycle after the strobe or level that causes them. The bench drives each stimulus for one cycle starting at a falling edge and samples at the next falling edge. The update-in-progress flag is then checked at 1 at that sample. It is checked at 0 one sample later in I2C mode, and two samples later in SPI mode, which pins the hold length exactly. The sweep covers base addresses from 0 up to 511 in both modes, so the saturation point falls at different access counts in different runs.

// File: rtl/cr_ptr_pkg.sv
package cr_ptr_pkg;
  localparam int STATUS_W = 32;
  localparam int RD_LSB   = 0;
  localparam int WR_LSB   = 16;
  localparam int BUSY_BIT = 30;
  localparam int UPD_BIT  = 31;

  typedef enum logic {
    MODE_I2C = 1'b0,
    MODE_SPI = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/cr_ptr_counter.sv
module cr_ptr_counter #(
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] base,
  input  logic             access,
  output logic [PTR_W-1:0] ptr,
  output logic             advance
);
  localparam logic [PTR_W-1:0] LAST = {PTR_W{1'b1}};

  logic [PTR_W-1:0] ptr_q;

  // load wins over an access in the same cycle; the last address holds
  assign advance = access & ~load & (ptr_q != LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= base;
    end else if (advance) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/cr_bus_tracker.sv
module cr_bus_tracker
  import cr_ptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_spi,
  input  logic i2c_start,
  input  logic i2c_restart,
  input  logic i2c_stop,
  input  logic match_ok,
  input  logic match_fail,
  input  logic spi_sel,
  output logic busy,
  output logic session,
  output logic load
);
  bus_mode_e mode;
  logic      busy_q;
  logic      matched_q;
  logic      sel_q;
  logic      i2c_close;

  assign mode      = bus_mode_e'(mode_spi);
  assign i2c_close = i2c_start | i2c_restart | i2c_stop | match_fail;

  always_comb begin
    if (mode == MODE_SPI) begin
      load    = spi_sel & ~sel_q;
      session = spi_sel & sel_q;
    end else begin
      load    = match_ok & ~i2c_close;
      session = matched_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      matched_q <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      sel_q <= spi_sel;
      if (mode == MODE_SPI) begin
        busy_q    <= spi_sel;
        matched_q <= 1'b0;
      end else begin
        if (i2c_start | i2c_restart) begin
          busy_q <= 1'b1;
        end else if (match_fail | i2c_stop) begin
          busy_q <= 1'b0;
        end
        if (i2c_close) begin
          matched_q <= 1'b0;
        end else if (match_ok) begin
          matched_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/cr_upd_timer.sv
module cr_upd_timer
  import cr_ptr_pkg::*;
#(
  parameter int I2C_HOLD = 1,
  parameter int SPI_HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_spi,
  input  logic trigger,
  input  logic busy,
  output logic upd
);
  localparam int MAX_HOLD = (I2C_HOLD > SPI_HOLD) ? I2C_HOLD : SPI_HOLD;
  localparam int CNT_W    = $clog2(MAX_HOLD + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hold_len;

  assign hold_len = (bus_mode_e'(mode_spi) == MODE_SPI) ? CNT_W'(SPI_HOLD)
                                                        : CNT_W'(I2C_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (trigger) begin
      cnt_q <= hold_len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign upd = (cnt_q != '0) & busy;
endmodule

// File: rtl/cr_ptr_tracker.sv
module cr_ptr_tracker
  import cr_ptr_pkg::*;
#(
  parameter int PTR_W    = 9,
  parameter int I2C_HOLD = 1,
  parameter int SPI_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_spi,
  input  logic [PTR_W-1:0] base_rd_addr,
  input  logic [PTR_W-1:0] base_wr_addr,
  input  logic             rd_strobe,
  input  logic             wr_strobe,
  input  logic             i2c_start,
  input  logic             i2c_restart,
  input  logic             i2c_stop,
  input  logic             addr_match_ok,
  input  logic             addr_match_fail,
  input  logic             spi_sel,
  output logic [31:0]      status_word
);
  localparam int NPTR = 2;  // index 0 = read side, 1 = write side

  logic             busy;
  logic             session;
  logic             load;
  logic             upd;
  logic [PTR_W-1:0] base_arr [NPTR];
  logic [PTR_W-1:0] ptr_arr  [NPTR];
  logic [NPTR-1:0]  access_vec;
  logic [NPTR-1:0]  advance_vec;

  assign base_arr[0] = base_rd_addr;
  assign base_arr[1] = base_wr_addr;
  assign access_vec  = {wr_strobe, rd_strobe} & {NPTR{session}};

  cr_bus_tracker u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_spi   (mode_spi),
    .i2c_start  (i2c_start),
    .i2c_restart(i2c_restart),
    .i2c_stop   (i2c_stop),
    .match_ok   (addr_match_ok),
    .match_fail (addr_match_fail),
    .spi_sel    (spi_sel),
    .busy       (busy),
    .session    (session),
    .load       (load)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    cr_ptr_counter #(.PTR_W(PTR_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .base   (base_arr[g]),
      .access (access_vec[g]),
      .ptr    (ptr_arr[g]),
      .advance(advance_vec[g])
    );
  end

  cr_upd_timer #(.I2C_HOLD(I2C_HOLD), .SPI_HOLD(SPI_HOLD)) u_upd (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_spi(mode_spi),
    .trigger (|advance_vec),
    .busy    (busy),
    .upd     (upd)
  );

  always_comb begin
    status_word                     = '0;
    status_word[RD_LSB +: PTR_W]    = ptr_arr[0];
    status_word[WR_LSB +: PTR_W]    = ptr_arr[1];
    status_word[BUSY_BIT]           = busy;
    status_word[UPD_BIT]            = upd;
  end
endmodule

// File: rtl/cr_ptr_tracker_chk.sv
module cr_ptr_tracker_chk #(
  parameter int PTR_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_spi,
  input logic [PTR_W-1:0] base_rd_addr,
  input logic [PTR_W-1:0] base_wr_addr,
  input logic             rd_strobe,
  input logic             wr_strobe,
  input logic             i2c_start,
  input logic             i2c_restart,
  input logic             addr_match_fail,
  input logic             spi_sel,
  input logic [31:0]      status_word
);
  localparam logic [PTR_W-1:0] LAST = {PTR_W{1'b1}};

  logic [PTR_W-1:0] rd_f;
  logic [PTR_W-1:0] wr_f;
  assign rd_f = status_word[PTR_W-1:0];
  assign wr_f = status_word[16 +: PTR_W];

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[15:9] == '0) && (status_word[29:25] == '0));

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_f == $past(rd_f)) || (rd_f == PTR_W'($past(rd_f) + 1'b1))
             || (rd_f == $past(base_rd_addr)));

  // R4
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wr_f == $past(wr_f)) || (wr_f == PTR_W'($past(wr_f) + 1'b1))
             || (wr_f == $past(base_wr_addr)));

  // R5
  rd_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_f == LAST) |=> (rd_f == LAST) || (rd_f == $past(base_rd_addr)));

  // R7
  i2c_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_spi && (i2c_start || i2c_restart)) |=> status_word[30]);

  // R7
  i2c_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_spi && addr_match_fail && !i2c_start && !i2c_restart) |=> !status_word[30]);

  // R8
  spi_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_spi |=> (status_word[30] == $past(spi_sel)));

  // R9
  upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[31]) |-> $past(rd_strobe || wr_strobe));
endmodule

bind cr_ptr_tracker cr_ptr_tracker_chk #(.PTR_W(PTR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_spi       (mode_spi),
  .base_rd_addr   (base_rd_addr),
  .base_wr_addr   (base_wr_addr),
  .rd_strobe      (rd_strobe),
  .wr_strobe      (wr_strobe),
  .i2c_start      (i2c_start),
  .i2c_restart    (i2c_restart),
  .addr_match_fail(addr_match_fail),
  .spi_sel        (spi_sel),
  .status_word    (status_word)
);

// File: tb/cr_ptr_tracker_tb.sv
module cr_ptr_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_spi = 1'b0;
  logic [8:0]  base_rd_addr = '0;
  logic [8:0]  base_wr_addr = '0;
  logic        rd_strobe = 1'b0;
  logic        wr_strobe = 1'b0;
  logic        i2c_start = 1'b0;
  logic        i2c_restart = 1'b0;
  logic        i2c_stop = 1'b0;
  logic        addr_match_ok = 1'b0;
  logic        addr_match_fail = 1'b0;
  logic        spi_sel = 1'b0;
  logic [31:0] status_word;

  int checks = 0;
  int failures = 0;
  int exp_rd = 0;
  int exp_wr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cr_ptr_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .mode_spi(mode_spi),
    .base_rd_addr(base_rd_addr), .base_wr_addr(base_wr_addr),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .i2c_start(i2c_start), .i2c_restart(i2c_restart), .i2c_stop(i2c_stop),
    .addr_match_ok(addr_match_ok), .addr_match_fail(addr_match_fail),
    .spi_sel(spi_sel), .status_word(status_word)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rd_f(); return int'(status_word[8:0]); endfunction
  function automatic int wr_f(); return int'(status_word[24:16]); endfunction
  function automatic int busy_f(); return int'(status_word[30]); endfunction
  function automatic int upd_f(); return int'(status_word[31]); endfunction

  task automatic step();
    @(negedge clk);
    chk("R1 reserved bits", int'({status_word[29:25], status_word[15:9]}), 0);
  endtask

  task automatic check_ptrs(input string tag);
    chk({tag, " rd"}, rd_f(), exp_rd);
    chk({tag, " wr"}, wr_f(), exp_wr);
  endtask

  task automatic i2c_session(input int br, input int bw, input int n);
    mode_spi = 1'b0;
    base_rd_addr = 9'(br);
    base_wr_addr = 9'(bw);
    i2c_start = 1'b1; step(); i2c_start = 1'b0;
    chk("R7 busy after START", busy_f(), 1);
    rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
    check_ptrs("R6 access before match ignored");
    addr_match_ok = 1'b1; step(); addr_match_ok = 1'b0;
    exp_rd = br; exp_wr = bw;
    check_ptrs("R3 I2C load");
    for (int i = 1; i <= n; i++) begin
      int adv;
      adv = (exp_rd < 511) ? 1 : 0;
      rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
      exp_rd = exp_rd + adv;
      chk("R4 R5 I2C read ptr", rd_f(), exp_rd);
      chk("R9 I2C upd on read", upd_f(), adv);
      step();
      chk("R9 I2C upd one cycle", upd_f(), 0);
      chk("R4 bytes read", rd_f() - br, (br + i > 511) ? 511 - br : i);
    end
    for (int i = 1; i <= n; i++) begin
      int adv;
      adv = (exp_wr < 511) ? 1 : 0;
      wr_strobe = 1'b1; step(); wr_strobe = 1'b0;
      exp_wr = exp_wr + adv;
      chk("R4 R5 I2C write ptr", wr_f(), exp_wr);
      chk("R9 I2C upd on write", upd_f(), adv);
      step();
      chk("R9 I2C upd one cycle", upd_f(), 0);
      chk("R4 bytes written", wr_f() - bw, (bw + i > 511) ? 511 - bw : i);
    end
    i2c_stop = 1'b1; step(); i2c_stop = 1'b0;
    chk("R7 busy cleared by STOP", busy_f(), 0);
    chk("R9 upd idle", upd_f(), 0);
    wr_strobe = 1'b1; rd_strobe = 1'b1; step(); wr_strobe = 1'b0; rd_strobe = 1'b0;
    check_ptrs("R6 access after STOP ignored");
    chk("R9 upd with no transfer", upd_f(), 0);
  endtask

  task automatic spi_session(input int br, input int bw, input int n);
    mode_spi = 1'b1;
    base_rd_addr = 9'(br);
    base_wr_addr = 9'(bw);
    spi_sel = 1'b1; rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
    exp_rd = br; exp_wr = bw;
    check_ptrs("R3 R6 SPI load, access in select cycle ignored");
    chk("R8 busy follows select", busy_f(), 1);
    for (int i = 1; i <= n; i++) begin
      int adv;
      adv = (exp_wr < 511) ? 1 : 0;
      wr_strobe = 1'b1; step(); wr_strobe = 1'b0;
      exp_wr = exp_wr + adv;
      chk("R4 R5 SPI write ptr", wr_f(), exp_wr);
      chk("R9 SPI upd first cycle", upd_f(), adv);
      step();
      chk("R9 SPI upd second cycle", upd_f(), adv);
      step();
      chk("R9 SPI upd ends", upd_f(), 0);
    end
    for (int i = 1; i <= n; i++) begin
      int adv;
      adv = (exp_rd < 511) ? 1 : 0;
      rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
      exp_rd = exp_rd + adv;
      chk("R4 R5 SPI read ptr", rd_f(), exp_rd);
      chk("R9 SPI upd first cycle", upd_f(), adv);
      step();
      chk("R9 SPI upd second cycle", upd_f(), adv);
      step();
      chk("R9 SPI upd ends", upd_f(), 0);
      chk("R4 SPI bytes read", rd_f() - br, (br + i > 511) ? 511 - br : i);
    end
    spi_sel = 1'b0; step();
    chk("R8 busy drops with select", busy_f(), 0);
    rd_strobe = 1'b1; wr_strobe = 1'b1; step(); rd_strobe = 1'b0; wr_strobe = 1'b0;
    check_ptrs("R6 SPI access while deselected ignored");
    mode_spi = 1'b0;
  endtask

  initial begin
    int bases [9] = '{0, 1, 100, 255, 256, 400, 505, 510, 511};
    step(); step();
    chk("R2 status in reset", int'(status_word), 0);
    rst_n = 1'b1;
    step();
    chk("R2 status after reset", int'(status_word), 0);

    foreach (bases[k]) begin
      i2c_session(bases[k], bases[8 - k], 8);
      spi_session(bases[8 - k], bases[k], 8);
    end

    // failed address match
    i2c_start = 1'b1; step(); i2c_start = 1'b0;
    chk("R7 busy after START", busy_f(), 1);
    addr_match_fail = 1'b1; step(); addr_match_fail = 1'b0;
    chk("R7 busy cleared by failed match", busy_f(), 0);
    rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
    check_ptrs("R6 access after failed match ignored");

    // RESTART inside a transaction, then reload with new bases
    base_rd_addr = 9'd20; base_wr_addr = 9'd40;
    i2c_start = 1'b1; step(); i2c_start = 1'b0;
    addr_match_ok = 1'b1; step(); addr_match_ok = 1'b0;
    exp_rd = 20; exp_wr = 40;
    check_ptrs("R3 load before RESTART");
    i2c_restart = 1'b1; step(); i2c_restart = 1'b0;
    chk("R7 busy held by RESTART", busy_f(), 1);
    wr_strobe = 1'b1; step(); wr_strobe = 1'b0;
    check_ptrs("R6 access after RESTART before match ignored");
    base_rd_addr = 9'd300; base_wr_addr = 9'd7;
    addr_match_ok = 1'b1; step(); addr_match_ok = 1'b0;
    exp_rd = 300; exp_wr = 7;
    check_ptrs("R3 reload after RESTART");
    i2c_stop = 1'b1; step(); i2c_stop = 1'b0;
    chk("R7 busy cleared by STOP", busy_f(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule